// File: doc/BRIEF.md
# Processor Memory Bus Interface Unit

This unit carries a processor's cache-miss reads and its stores onto a shared memory bus whose address and data travel on the same wires. Every transaction opens with a one-cycle address phase, in which the address is driven and a latch strobe is raised. A data phase follows. During the data phase a write drives its data word until memory acknowledges it. A read releases the wires. Memory then pushes one or four words into an internal read buffer, one word for each pulse of a separate capture strobe.

One output pin has two meanings, depending on the direction of the transaction. On a read it requests an aligned four-word block. Every instruction-miss read does this, and a data-miss read does it only when a configuration input was high during reset. On a write it tells memory that this write follows another write to the same page, so a page-mode memory can retire it quickly.

A bus-error input ends the current transaction. On a read it also raises an exception flag. An external DMA master can request the bus. The unit grants it only between transactions and turns all of its drivers off while the grant lasts.

Top module: `mem_bus_ifc`

## Requirements
- R1: After a synchronous active-low reset, the unit is idle. req_ready_o=1, ctl_oe_o=1, and busgnt_o, rd_o, wr_o, ale_o, ad_oe_o, burst_near_o and rsp_valid_o are all 0. The read buffer holds zeros.
- R2: An accepted request gives exactly one address-phase cycle (ale_o=1, ad_oe_o=1, ad_o = address zero-extended), followed by data-phase cycles with ale_o=0. During a read's data phase ad_oe_o is 0.
- R3: In a write's data phase, ad_o carries the write data. The write ends on the clock edge where ack_i=1, and rsp_valid_o pulses high for exactly one cycle after that edge.
- R4: An instruction-miss read (req_icache_i=1) asserts burst_near_o for the whole read. It drives the address with its low log2(BURST_WORDS) bits forced to zero. It stores successive capture pulses in rbuf_o word slots 0, 1, 2, 3.
- R5: A data-miss read bursts only if cfg_dburst_i was 1 on the last reset cycle. Otherwise it is a single read: burst_near_o=0, the full address is driven, and one capture pulse fills slot 0.
- R6: A read ends only when its final capture pulse has arrived and ack_i has been seen, either in an earlier data-phase cycle or in that same cycle. Capture pulses outside a read's data phase leave rbuf_o unchanged.
- R7: On a write, burst_near_o is 1 exactly when the previous transaction was a write whose address bits above PAGE_OFF_W equal those of this write.
- R8: Reset, any read, and any bus grant clear the page history, so the next write has burst_near_o=0.
- R9: berr_i=1 in a data phase ends the transaction, with rsp_valid_o=1 and rsp_err_o=1. buserr_exc_o=1 follows only for a read. berr_i while idle has no effect.
- R10: busgnt_o rises only from idle, one cycle after busreq_i is seen. While the grant lasts, ctl_oe_o, ad_oe_o, rd_o and wr_o are 0 and requests are refused. busgnt_o falls one cycle after busreq_i is low. A busreq_i that arrives during a transaction waits until that transaction ends.
- R11: rd_o and wr_o are never both high. rd_o marks reads and wr_o marks writes, in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dburst_i | input | 1 | Data-miss burst enable, latched while in reset |
| req_valid_i | input | 1 | Request from the caches or the store path |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_icache_i | input | 1 | Read comes from an instruction-cache miss |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| rsp_valid_o | output | 1 | One-cycle transaction-end pulse |
| rsp_err_o | output | 1 | Transaction ended by bus error |
| buserr_exc_o | output | 1 | Bus-error exception for a read |
| rbuf_o | output | BURST_WORDS*DATA_W | Read buffer, slot k at [k*DATA_W +: DATA_W] |
| ad_o | output | DATA_W | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | DATA_W | Multiplexed bus in |
| ale_o | output | 1 | Address-phase strobe |
| rd_o | output | 1 | Read in progress |
| wr_o | output | 1 | Write in progress |
| burst_near_o | output | 1 | Block read request, or same-page write |
| ctl_oe_o | output | 1 | Drive enable for strobes |
| ack_i | input | 1 | Memory acknowledge |
| rbuf_en_i | input | 1 | Capture one read word |
| berr_i | input | 1 | Bus error |
| busreq_i | input | 1 | External master bus request |
| busgnt_o | output | 1 | Bus granted to external master |

## Verification
The bench builds the unit with ADDR_W=10, DATA_W=16, PAGE_OFF_W=3 and BURST_WORDS=4. With these values a page is only eight words, so a short address list covers same-page, adjacent-page and far-page pairs. The bench sweeps every ordered pair of that list for the same-page flag. The 16-bit data path lets each captured word carry a distinct value computed from its address and slot, so slot order and block alignment are checked word by word. The bench also resets twice, once with the data-burst option off and once with it on.

// File: rtl/mbi_pkg.sv
// Package: shared types for the memory bus interface unit.
// Assumes nothing beyond a 2-bit state encoding.
package mbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_GRANT = 2'd3
    } mbi_state_e;
endpackage

// File: rtl/mbi_near_track.sv
// Module: page history for back-to-back writes.
// Remembers the page of the last completed write. Reports whether a
// candidate write hits that page. Assumes clear_i and wr_done_i never
// arrive in the same cycle.
module mbi_near_track #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] cand_page_i,
    input  logic              cand_write_i,
    input  logic [PAGE_W-1:0] done_page_i,
    input  logic              wr_done_i,
    input  logic              clear_i,
    output logic              near_o
);
    logic              hist_vld_q;
    logic [PAGE_W-1:0] hist_page_q;

    // Record the page of each finished write; drop history on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_vld_q  <= 1'b0;
            hist_page_q <= '0;
        end else if (clear_i) begin
            hist_vld_q  <= 1'b0;
        end else if (wr_done_i) begin
            hist_vld_q  <= 1'b1;
            hist_page_q <= done_page_i;
        end
    end

    // Compare the candidate against the remembered page.
    always_comb near_o = cand_write_i && hist_vld_q && (cand_page_i == hist_page_q);

    AST_CLEAR_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !near_o); // R8
endmodule

// File: rtl/mbi_read_buf.sv
// Module: read buffer of WORDS entries.
// Stores one word per capture pulse, slot by slot, starting at slot 0
// after start_i. Assumes WORDS is a power of two, at least 2.
module mbi_read_buf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    cap_i,
    input  logic                    burst_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic                    last_o,
    output logic [WORDS*DATA_W-1:0] buf_o
);
    localparam int CNT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

    logic [CNT_W-1:0] slot_q;

    // Advance the slot pointer on each capture; rewind on a new read.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_q <= '0;
        else if (start_i) slot_q <= '0;
        else if (cap_i)   slot_q <= slot_q + 1'b1;
    end

    // Flag the capture that completes the read.
    always_comb last_o = cap_i && (!burst_i || slot_q == LAST_IDX);

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [DATA_W-1:0] word_q;
        // Load this slot when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                               word_q <= '0;
            else if (cap_i && slot_q == CNT_W'(g))    word_q <= data_i;
        end
        assign buf_o[g*DATA_W +: DATA_W] = word_q;
    end

    AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !last_o || !burst_i || !cap_i || (WORDS == 1)); // R4
endmodule

// File: rtl/mem_bus_ifc.sv
// Module: processor-side memory bus interface unit (top).
// Runs one transaction at a time on a multiplexed address/data bus:
// an address phase, then a data phase. Grants the bus to an external
// master only while idle. Assumes ADDR_W <= DATA_W and
// ADDR_W > PAGE_OFF_W.
module mem_bus_ifc #(
    parameter int ADDR_W      = 30,
    parameter int DATA_W      = 32,
    parameter int PAGE_OFF_W  = 8,
    parameter int BURST_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_dburst_i,
    input  logic                          req_valid_i,
    input  logic                          req_write_i,
    input  logic                          req_icache_i,
    input  logic [ADDR_W-1:0]             req_addr_i,
    input  logic [DATA_W-1:0]             req_wdata_i,
    output logic                          req_ready_o,
    output logic                          rsp_valid_o,
    output logic                          rsp_err_o,
    output logic                          buserr_exc_o,
    output logic [BURST_WORDS*DATA_W-1:0] rbuf_o,
    output logic [DATA_W-1:0]             ad_o,
    output logic                          ad_oe_o,
    input  logic [DATA_W-1:0]             ad_i,
    output logic                          ale_o,
    output logic                          rd_o,
    output logic                          wr_o,
    output logic                          burst_near_o,
    output logic                          ctl_oe_o,
    input  logic                          ack_i,
    input  logic                          rbuf_en_i,
    input  logic                          berr_i,
    input  logic                          busreq_i,
    output logic                          busgnt_o
);
    import mbi_pkg::*;

    localparam int PAGE_W = ADDR_W - PAGE_OFF_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = ~(ADDR_W'(BURST_WORDS - 1));

    mbi_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q, burst_q, near_q, ack_seen_q, dburst_q;
    logic              rsp_valid_q, rsp_err_q, exc_q;
    logic              accept, in_txn, in_data, done, cap, last_cap, near_c;
    logic              wr_done, hist_clear;
    logic [ADDR_W-1:0] addr_drive;

    // Decode the request handshake and the phase qualifiers.
    always_comb begin
        req_ready_o = (state_q == ST_IDLE) && !busreq_i;
        accept      = req_ready_o && req_valid_i;
        in_txn      = (state_q == ST_ADDR) || (state_q == ST_DATA);
        in_data     = (state_q == ST_DATA);
        cap         = in_data && !write_q && rbuf_en_i && !berr_i;
        done        = in_data && (berr_i ||
                      (write_q ? ack_i : (last_cap && (ack_i || ack_seen_q))));
        wr_done     = done && write_q;
        hist_clear  = (accept && !req_write_i) || ((state_q == ST_IDLE) && busreq_i);
    end

    // Latch the data-miss burst option while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) dburst_q <= cfg_dburst_i;
    end

    // Sequence idle, address phase, data phase and bus grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (busreq_i)     state_q <= ST_GRANT;
                          else if (accept)  state_q <= ST_ADDR;
                ST_ADDR:                    state_q <= ST_DATA;
                ST_DATA:  if (done)         state_q <= ST_IDLE;
                ST_GRANT: if (!busreq_i)    state_q <= ST_IDLE;
                default:                    state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the accepted request and its burst or same-page decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            burst_q <= 1'b0;
            near_q  <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            write_q <= req_write_i;
            burst_q <= !req_write_i && (req_icache_i || dburst_q);
            near_q  <= near_c;
        end
    end

    // Remember an acknowledge that arrives before the final read word.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)                 ack_seen_q <= 1'b0;
        else if (in_data && !write_q && ack_i) ack_seen_q <= 1'b1;
    end

    // Register the end-of-transaction pulse and its error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            exc_q       <= 1'b0;
        end else begin
            rsp_valid_q <= done;
            rsp_err_q   <= done && berr_i;
            exc_q       <= done && berr_i && !write_q;
        end
    end

    mbi_near_track #(.PAGE_W(PAGE_W)) near_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_page_i  (req_addr_i[ADDR_W-1:PAGE_OFF_W]),
        .cand_write_i (req_write_i),
        .done_page_i  (addr_q[ADDR_W-1:PAGE_OFF_W]),
        .wr_done_i    (wr_done),
        .clear_i      (hist_clear),
        .near_o       (near_c)
    );

    mbi_read_buf #(.DATA_W(DATA_W), .WORDS(BURST_WORDS)) rbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .cap_i   (cap),
        .burst_i (burst_q),
        .data_i  (ad_i),
        .last_o  (last_cap),
        .buf_o   (rbuf_o)
    );

    // Drive the bus pins from the current phase.
    always_comb begin
        addr_drive   = burst_q ? (addr_q & BLK_MASK) : addr_q;
        ale_o        = (state_q == ST_ADDR);
        rd_o         = in_txn && !write_q;
        wr_o         = in_txn && write_q;
        burst_near_o = in_txn && (write_q ? near_q : burst_q);
        ad_oe_o      = ale_o || (in_data && write_q);
        ad_o         = ale_o ? DATA_W'(addr_drive) : wdata_q;
        ctl_oe_o     = (state_q != ST_GRANT);
        busgnt_o     = (state_q == ST_GRANT);
        rsp_valid_o  = rsp_valid_q;
        rsp_err_o    = rsp_err_q;
        buserr_exc_o = exc_q;
    end

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o)); // R11
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o && (rd_o || wr_o)); // R2
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o); // R3
    AST_EXC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buserr_exc_o |-> rsp_valid_o && rsp_err_o && $past(rd_o)); // R9
    AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busgnt_o |-> !rd_o && !wr_o && !ad_oe_o && !ctl_oe_o); // R10
    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        busgnt_o && !busreq_i |=> !busgnt_o); // R10
    AST_GNT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busgnt_o) |-> $past(busreq_i) && $past(!rd_o && !wr_o)); // R10
endmodule

// File: tb/mem_bus_ifc_tb_top.sv
`timescale 1ns/1ps
module mem_bus_ifc_tb_top;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int PO = 3;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dburst = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_icache = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, buserr_exc;
    logic [BW*DW-1:0] rbuf;
    logic [DW-1:0] ad_o;
    logic ad_oe;
    logic [DW-1:0] ad_i = '0;
    logic ale, rd, wr, bnear, ctl_oe;
    logic ack = 1'b0, rbuf_en = 1'b0, berr = 1'b0, busreq = 1'b0;
    logic busgnt;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    mem_bus_ifc #(.ADDR_W(AW), .DATA_W(DW), .PAGE_OFF_W(PO), .BURST_WORDS(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dburst_i(cfg_dburst),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_icache_i(req_icache),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .buserr_exc_o(buserr_exc),
        .rbuf_o(rbuf), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .ale_o(ale),
        .rd_o(rd), .wr_o(wr), .burst_near_o(bnear), .ctl_oe_o(ctl_oe),
        .ack_i(ack), .rbuf_en_i(rbuf_en), .berr_i(berr), .busreq_i(busreq),
        .busgnt_o(busgnt)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic cfg);
        rst_n = 1'b0;
        cfg_dburst = cfg;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic exp_near, input int delay, input logic with_berr);
        req_valid = 1'b1; req_write = 1'b1; req_icache = 1'b0; req_addr = a; req_wdata = d;
        tick();
        req_valid = 1'b0;
        chk(ale, 1, "R2", "write ale");
        chk(ad_o, DW'(a), "R2", "write address phase");
        chk({rd, wr}, 2'b01, "R11", "write strobes");
        chk(bnear, exp_near, "R7", "same-page flag");
        tick();
        chk({ale, ad_oe}, 2'b01, "R2", "write data phase drive");
        chk(ad_o, d, "R3", "write data");
        for (int i = 0; i < delay; i++) begin
            tick();
            chk(rsp_valid, 0, "R3", "no end before ack");
        end
        if (with_berr) berr = 1'b1; else ack = 1'b1;
        tick();
        ack = 1'b0; berr = 1'b0;
        chk(rsp_valid, 1, "R3", "write end pulse");
        chk(rsp_err, with_berr, "R9", "write error flag");
        chk(buserr_exc, 0, "R9", "no exception on write");
        tick();
        chk(rsp_valid, 0, "R3", "pulse single cycle");
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic ic, input logic exp_burst,
                           input logic ack_early);
        int n;
        logic [AW-1:0] base;
        n = exp_burst ? BW : 1;
        base = exp_burst ? (a & ~AW'(BW - 1)) : a;
        req_valid = 1'b1; req_write = 1'b0; req_icache = ic; req_addr = a;
        tick();
        req_valid = 1'b0;
        chk({rd, wr, ale}, 3'b101, "R11", "read strobes");
        chk(bnear, exp_burst, exp_burst ? "R4" : "R5", "burst request");
        chk(ad_o, DW'(base), "R4", "read address aligned");
        tick();
        chk(ad_oe, 0, "R2", "read releases bus");
        chk(bnear, exp_burst, "R4", "burst held in data phase");
        if (ack_early) begin
            ack = 1'b1;
            tick();
            ack = 1'b0;
            chk(rsp_valid, 0, "R6", "ack alone does not end read");
        end
        for (int k = 0; k < n; k++) begin
            rbuf_en = 1'b1;
            ad_i = DW'(a) * 16'd7 + DW'(k) + 16'h1000;
            ack = (k == n - 1) && !ack_early;
            tick();
            rbuf_en = 1'b0; ack = 1'b0;
            if (k < n - 1) chk(rsp_valid, 0, "R6", "read open before last word");
        end
        chk(rsp_valid, 1, "R6", "read end pulse");
        chk({rsp_err, buserr_exc}, 2'b00, "R9", "clean read");
        for (int k = 0; k < n; k++)
            chk(rbuf[k*DW +: DW], DW'(a) * 16'd7 + DW'(k) + 16'h1000,
                exp_burst ? "R4" : "R5", "buffer slot");
        tick();
    endtask

    task automatic grant_cycle();
        busreq = 1'b1;
        tick();
        chk(busgnt, 1, "R10", "grant from idle");
        busreq = 1'b0;
        tick();
        chk(busgnt, 0, "R10", "grant released");
    endtask

    initial begin
        logic [AW-1:0] pts [8];
        pts[0] = 10'h000; pts[1] = 10'h005; pts[2] = 10'h007; pts[3] = 10'h008;
        pts[4] = 10'h00F; pts[5] = 10'h3F8; pts[6] = 10'h3FF; pts[7] = 10'h200;
        @(negedge clk);
        do_reset(1'b0);
        // R1 reset state
        chk({busgnt, rd, wr, ale, ad_oe, bnear, rsp_valid}, 7'b0, "R1", "idle outputs");
        chk({req_ready, ctl_oe}, 2'b11, "R1", "ready and drivers on");
        chk(rbuf, '0, "R1", "buffer cleared");
        // R6 capture pulse while idle is ignored
        rbuf_en = 1'b1; ad_i = 16'h5A5A;
        tick();
        rbuf_en = 1'b0;
        chk(rbuf, '0, "R6", "idle capture ignored");
        // R9 bus error while idle ignored
        berr = 1'b1;
        tick();
        berr = 1'b0;
        chk({rsp_valid, rsp_err, buserr_exc}, 3'b0, "R9", "idle berr ignored");
        // R4 instruction-miss bursts
        do_read(10'h013, 1'b1, 1'b1, 1'b0);
        do_read(10'h1FE, 1'b1, 1'b1, 1'b1);
        // R5 data-miss single reads with option off
        do_read(10'h0A7, 1'b0, 1'b0, 1'b0);
        do_read(10'h2C1, 1'b0, 1'b0, 1'b1);
        // R7 sweep of address pairs; grant in between clears history (R8)
        foreach (pts[i]) foreach (pts[j]) begin
            grant_cycle();
            do_write(pts[i], 16'h1111, 1'b0, 0, 1'b0);
            do_write(pts[j], 16'h2222 + DW'(j), (pts[i] >> PO) == (pts[j] >> PO), (i + j) % 3, 1'b0);
        end
        // R8 an intervening read clears history
        do_write(10'h040, 16'hAAAA, 1'b0, 0, 1'b0);
        do_read(10'h041, 1'b0, 1'b0, 1'b0);
        do_write(10'h042, 16'hBBBB, 1'b0, 0, 1'b0);
        do_write(10'h043, 16'hCCCC, 1'b1, 1, 1'b0);
        // R9 erroring write still counts as a write for the page history
        do_write(10'h044, 16'hDDDD, 1'b1, 0, 1'b1);
        do_write(10'h045, 16'hEEEE, 1'b1, 0, 1'b0);
        // R9 read ended by bus error
        req_valid = 1'b1; req_write = 1'b0; req_icache = 1'b1; req_addr = 10'h100;
        tick();
        req_valid = 1'b0;
        tick();
        berr = 1'b1;
        tick();
        berr = 1'b0;
        chk({rsp_valid, rsp_err, buserr_exc}, 3'b111, "R9", "read bus error exception");
        tick();
        // R10 request during a transaction waits; grant blocks requests
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h300; req_wdata = 16'h1234;
        tick();
        req_valid = 1'b0;
        busreq = 1'b1;
        tick();
        chk(busgnt, 0, "R10", "no grant mid-transaction");
        ack = 1'b1;
        tick();
        ack = 1'b0;
        chk(busgnt, 0, "R10", "grant waits one idle cycle");
        chk(req_ready, 0, "R10", "request refused while bus requested");
        req_valid = 1'b1; req_write = 1'b0; req_icache = 1'b1;
        tick();
        chk(busgnt, 1, "R10", "grant after transaction");
        chk({ctl_oe, ad_oe, rd, wr}, 4'b0, "R10", "drivers off in grant");
        tick();
        chk({busgnt, rd}, 2'b10, "R10", "request blocked during grant");
        req_valid = 1'b0;
        busreq = 1'b0;
        tick();
        chk(busgnt, 0, "R10", "release one cycle after request drops");
        // R8 grant cleared history
        do_write(10'h301, 16'h4321, 1'b0, 0, 1'b0);
        // R8 reset clears history; R5 burst option latched at reset
        do_reset(1'b1);
        cfg_dburst = 1'b0;
        do_write(10'h302, 16'h0F0F, 1'b0, 0, 1'b0);
        do_read(10'h0B6, 1'b0, 1'b1, 1'b0);
        do_reset(1'b0);
        do_read(10'h0B6, 1'b0, 1'b0, 1'b0);
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule